// File: doc/BRIEF.md
# Nested Trap Return-State Stack

This block keeps the exception-return state of a machine-mode core safe while NMIs and exceptions nest inside one another. Beside the live return PC, cause and detail-cause registers it holds two further save levels for each of them. It also holds a packed status word that keeps, for each save level, the previous privilege mode, the previous interrupt enable and the previous sub-mode type. Together these let handlers nest three deep and still unwind in order.

When a trap is taken, every chain moves one level deeper and the live registers load the new trap's PC, cause and detail cause. At the same time the first status level loads the core's current status fields. When the handler returns and the live cause marks a non-interrupt trap, every chain moves one level back toward the live registers. Software reaches all ten registers through one select/write-data/read-data port. Trap arbitration and the pipeline sit outside this block.

Top module: `trap_nest_stack`

## Requirements
- R1: After reset every one of the ten registers reads 0.
- R2: On `trap_valid` the PC chain shifts at the next clock edge. Level 2 takes the old level 1, level 1 takes the old live PC, and the live PC takes `trap_pc`.
- R3: On `trap_valid` the cause chain and the detail-cause chain shift in the same way. The live cause takes `trap_cause` and the live detail cause takes `trap_dcause`.
- R4: On `trap_valid` level 1 of the status stack takes `cur_ptyp`, `cur_mpp` and `cur_mpie`, and level 2 takes the old level 1. In the status word, level 1 sits at ptyp [7:6], mpp [2:1], mpie [0] and level 2 sits at ptyp [15:14], mpp [10:9], mpie [8].
- R5: On `mret_valid` without `trap_valid`, when bit 31 of the live cause is 0, every chain pops: the live register takes level 1, level 1 takes level 2, and level 2 keeps its value. The status stack pops the same way: level 1 takes level 2 and level 2 keeps its value.
- R6: On `mret_valid` when bit 31 of the live cause is 1, no register changes.
- R7: A trap taken while both save levels are occupied discards the old level-2 contents.
- R8: Software selects a register with `csr_sel`: 0/1/2 = live/level-1/level-2 PC, 3/4/5 = cause, 6/7/8 = detail cause, 9 = status word. `csr_rdata` shows the selected register combinationally, and `csr_we` writes `csr_wdata` at the next clock edge.
- R9: Status-word bits outside the R4 fields read 0 and ignore writes. Detail-cause registers keep bits [1:0] only, and their upper bits read 0.
- R10: A software write in the same cycle as a trap entry or a taken pop is dropped. When `trap_valid` and `mret_valid` arrive together, only the trap entry takes effect.
- R11: Select codes 10 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trap_valid | input | 1 | Trap entry strobe |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_cause | input | XLEN | Cause of the new trap |
| trap_dcause | input | 2 | Detail cause of the new trap |
| mret_valid | input | 1 | Trap return strobe |
| cur_mpp | input | 2 | Current previous-privilege field |
| cur_mpie | input | 1 | Current previous-interrupt-enable field |
| cur_ptyp | input | 2 | Current previous sub-mode type |
| csr_sel | input | 4 | Register select (R8 encoding) |
| csr_we | input | 1 | Software write enable |
| csr_wdata | input | XLEN | Software write data |
| csr_rdata | output | XLEN | Read data of the selected register |

## Verification
The bench runs 32 nested entries, each with distinct PC, cause, detail-cause and status-field values, and interleaves pops with them. This shows whether each chain shifts in the right direction and by one level, and the distinct values show when a level has been dropped on overflow. It tries a return both with the live cause's interrupt bit set and with it clear, which separates pop from hold. It also hits every select code with all-ones and patterned writes, which exposes reserved-bit leaks and decode aliasing. Finally it puts a software write in the same cycle as a trap or a pop, and a trap together with a return, to show which source wins.

// File: rtl/trap_nest_pkg.sv
package trap_nest_pkg;
  localparam int unsigned SAVE_LEVELS = 2;
  localparam int unsigned CHAIN_DEPTH = SAVE_LEVELS + 1;
  localparam int unsigned DC_W        = 2;
  localparam int unsigned ST_W        = 5;
  localparam int unsigned NUM_GROUPS  = 3;
  localparam int unsigned STAT_SEL    = NUM_GROUPS * CHAIN_DEPTH;
  localparam int unsigned SEL_W       = $clog2(STAT_SEL + 1);
  localparam int unsigned ST_STRIDE   = 8;

  typedef enum int unsigned {
    GRP_EPC = 0,
    GRP_CAU = 1,
    GRP_DC  = 2
  } grp_e;
endpackage

// File: rtl/nest_chain.sv
module nest_chain #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      pop,
  input  logic [W-1:0]              push_val,
  input  logic [DEPTH-1:0]          wr_en,
  input  logic [DEPTH-1:0][W-1:0]   wr_val,
  output logic [DEPTH-1:0][W-1:0]   q
);
  logic [DEPTH-1:0][W-1:0] q_nx;
  logic                    upd;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : gen_lvl
      logic [W-1:0] deeper_src;
      logic [W-1:0] upper_src;
      if (i == 0) begin : g_top
        assign deeper_src = push_val;
      end else begin : g_mid
        assign deeper_src = q[i-1];
      end
      if (i == DEPTH - 1) begin : g_last
        assign upper_src = q[i];
      end else begin : g_inner
        assign upper_src = q[i+1];
      end
      assign q_nx[i] = push      ? deeper_src :
                       pop       ? upper_src  :
                       wr_en[i]  ? wr_val[i]  : q[i];
    end
  endgenerate

  assign upd = push | pop | (|wr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= q_nx;
    end
  end

  p_push_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (q[0] == $past(push_val)) && (q[1] == $past(q[0])));

  p_pop_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (q[0] == $past(q[1])) && (q[DEPTH-1] == $past(q[DEPTH-1])));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && (wr_en == '0)) |=> $stable(q));
endmodule

// File: rtl/nest_csr_port.sv
module nest_csr_port
  import trap_nest_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [SEL_W-1:0]                    sel,
  input  logic                                we,
  input  logic                                hw_busy,
  input  logic [XLEN-1:0]                     wdata,
  input  logic [CHAIN_DEPTH-1:0][XLEN-1:0]    epc_q,
  input  logic [CHAIN_DEPTH-1:0][XLEN-1:0]    cau_q,
  input  logic [CHAIN_DEPTH-1:0][DC_W-1:0]    dc_q,
  input  logic [SAVE_LEVELS-1:0][ST_W-1:0]    st_q,
  output logic [CHAIN_DEPTH-1:0]              epc_we,
  output logic [CHAIN_DEPTH-1:0]              cau_we,
  output logic [CHAIN_DEPTH-1:0]              dc_we,
  output logic [SAVE_LEVELS-1:0]              st_we,
  output logic [SAVE_LEVELS-1:0][ST_W-1:0]    st_wval,
  output logic [XLEN-1:0]                     rdata
);
  logic we_ok;
  assign we_ok = we & ~hw_busy;

  always_comb begin
    epc_we = '0;
    cau_we = '0;
    dc_we  = '0;
    st_we  = '0;
    rdata  = '0;
    for (int l = 0; l < CHAIN_DEPTH; l++) begin
      if (sel == SEL_W'(GRP_EPC * CHAIN_DEPTH + l)) begin
        epc_we[l] = we_ok;
        rdata     = epc_q[l];
      end
      if (sel == SEL_W'(GRP_CAU * CHAIN_DEPTH + l)) begin
        cau_we[l] = we_ok;
        rdata     = cau_q[l];
      end
      if (sel == SEL_W'(GRP_DC * CHAIN_DEPTH + l)) begin
        dc_we[l] = we_ok;
        rdata    = XLEN'(dc_q[l]);
      end
    end
    if (sel == SEL_W'(STAT_SEL)) begin
      for (int k = 0; k < SAVE_LEVELS; k++) begin
        st_we[k] = we_ok;
        rdata[k*ST_STRIDE +: ST_STRIDE] = {st_q[k][4:3], 3'b000, st_q[k][2:0]};
      end
    end
  end

  always_comb begin
    for (int k = 0; k < SAVE_LEVELS; k++) begin
      st_wval[k] = {wdata[k*ST_STRIDE+6 +: 2], wdata[k*ST_STRIDE +: 3]};
    end
  end
endmodule

// File: rtl/trap_nest_stack.sv
module trap_nest_stack
  import trap_nest_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trap_valid,
  input  logic [XLEN-1:0]      trap_pc,
  input  logic [XLEN-1:0]      trap_cause,
  input  logic [DC_W-1:0]      trap_dcause,
  input  logic                 mret_valid,
  input  logic [1:0]           cur_mpp,
  input  logic                 cur_mpie,
  input  logic [1:0]           cur_ptyp,
  input  logic [SEL_W-1:0]     csr_sel,
  input  logic                 csr_we,
  input  logic [XLEN-1:0]      csr_wdata,
  output logic [XLEN-1:0]      csr_rdata
);
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [CHAIN_DEPTH-1:0][XLEN-1:0]  epc_q, cau_q, epc_wv, cau_wv;
  logic [CHAIN_DEPTH-1:0][DC_W-1:0]  dc_q, dc_wv;
  logic [SAVE_LEVELS-1:0][ST_W-1:0]  st_q, st_wval;
  logic [CHAIN_DEPTH-1:0]            epc_we, cau_we, dc_we;
  logic [SAVE_LEVELS-1:0]            st_we;
  logic                              hw_push, hw_pop, hw_busy;

  assign hw_push = trap_valid;
  assign hw_pop  = mret_valid & ~trap_valid & ~cau_q[0][XLEN-1];
  assign hw_busy = hw_push | hw_pop;

  assign epc_wv = {CHAIN_DEPTH{csr_wdata}};
  assign cau_wv = {CHAIN_DEPTH{csr_wdata}};
  assign dc_wv  = {CHAIN_DEPTH{csr_wdata[DC_W-1:0]}};

  nest_chain #(.W(XLEN), .DEPTH(CHAIN_DEPTH)) u_epc (
    .clk(clk), .rst_n(rst_sync_n), .push(hw_push), .pop(hw_pop),
    .push_val(trap_pc), .wr_en(epc_we), .wr_val(epc_wv), .q(epc_q));

  nest_chain #(.W(XLEN), .DEPTH(CHAIN_DEPTH)) u_cau (
    .clk(clk), .rst_n(rst_sync_n), .push(hw_push), .pop(hw_pop),
    .push_val(trap_cause), .wr_en(cau_we), .wr_val(cau_wv), .q(cau_q));

  nest_chain #(.W(DC_W), .DEPTH(CHAIN_DEPTH)) u_dc (
    .clk(clk), .rst_n(rst_sync_n), .push(hw_push), .pop(hw_pop),
    .push_val(trap_dcause), .wr_en(dc_we), .wr_val(dc_wv), .q(dc_q));

  nest_chain #(.W(ST_W), .DEPTH(SAVE_LEVELS)) u_st (
    .clk(clk), .rst_n(rst_sync_n), .push(hw_push), .pop(hw_pop),
    .push_val({cur_ptyp, cur_mpp, cur_mpie}), .wr_en(st_we), .wr_val(st_wval), .q(st_q));

  nest_csr_port #(.XLEN(XLEN)) u_port (
    .sel(csr_sel), .we(csr_we), .hw_busy(hw_busy), .wdata(csr_wdata),
    .epc_q(epc_q), .cau_q(cau_q), .dc_q(dc_q), .st_q(st_q),
    .epc_we(epc_we), .cau_we(cau_we), .dc_we(dc_we), .st_we(st_we),
    .st_wval(st_wval), .rdata(csr_rdata));

  p_intr_mret_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mret_valid && !trap_valid && !csr_we && cau_q[0][XLEN-1])
      |=> $stable(epc_q) && $stable(cau_q) && $stable(dc_q) && $stable(st_q));

  p_oldest_lost_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_valid |=> (epc_q[CHAIN_DEPTH-1] == $past(epc_q[CHAIN_DEPTH-2]))
                && (st_q[SAVE_LEVELS-1] == $past(st_q[SAVE_LEVELS-2])));

  p_hw_over_sw_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_valid && csr_we && csr_sel == SEL_W'(0)) |=> epc_q[0] == $past(trap_pc));

  p_dc_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_sel >= SEL_W'(GRP_DC * CHAIN_DEPTH) && csr_sel < SEL_W'(STAT_SEL))
      |-> csr_rdata[XLEN-1:DC_W] == '0);

  p_stat_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_sel == SEL_W'(STAT_SEL)) |-> (csr_rdata[5:3] == 3'b000) && (csr_rdata[13:11] == 3'b000)
      && (csr_rdata[XLEN-1:SAVE_LEVELS*ST_STRIDE] == '0));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_sel > SEL_W'(STAT_SEL)) |-> csr_rdata == '0);
endmodule

// File: tb/sim_trap_nest_stack.sv
module sim_trap_nest_stack;
  localparam int CLK_PERIOD = 10;
  localparam int NSEL = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_valid, mret_valid, cur_mpie, csr_we;
  logic [31:0] trap_pc, trap_cause, csr_wdata, csr_rdata;
  logic [1:0]  trap_dcause, cur_mpp, cur_ptyp;
  logic [3:0]  csr_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_epc [3];
  logic [31:0] m_cau [3];
  logic [1:0]  m_dc  [3];
  logic [4:0]  m_st  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_nest_stack u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_pc(trap_pc),
    .trap_cause(trap_cause), .trap_dcause(trap_dcause), .mret_valid(mret_valid),
    .cur_mpp(cur_mpp), .cur_mpie(cur_mpie), .cur_ptyp(cur_ptyp),
    .csr_sel(csr_sel), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

  function automatic logic [31:0] exp_rd(int s);
    if (s < 3) return m_epc[s];
    if (s < 6) return m_cau[s-3];
    if (s < 9) return {30'b0, m_dc[s-6]};
    if (s == 9) return {16'b0, m_st[1][4:3], 3'b0, m_st[1][2:0],
                               m_st[0][4:3], 3'b0, m_st[0][2:0]};
    return 32'h0;
  endfunction

  task automatic m_push(logic [31:0] pc, logic [31:0] c, logic [1:0] d, logic [4:0] st);
    m_epc[2] = m_epc[1]; m_epc[1] = m_epc[0]; m_epc[0] = pc;
    m_cau[2] = m_cau[1]; m_cau[1] = m_cau[0]; m_cau[0] = c;
    m_dc[2]  = m_dc[1];  m_dc[1]  = m_dc[0];  m_dc[0]  = d;
    m_st[1]  = m_st[0];  m_st[0]  = st;
  endtask

  task automatic m_pop();
    m_epc[0] = m_epc[1]; m_epc[1] = m_epc[2];
    m_cau[0] = m_cau[1]; m_cau[1] = m_cau[2];
    m_dc[0]  = m_dc[1];  m_dc[1]  = m_dc[2];
    m_st[0]  = m_st[1];
  endtask

  task automatic m_write(int s, logic [31:0] v);
    if (s < 3) m_epc[s] = v;
    else if (s < 6) m_cau[s-3] = v;
    else if (s < 9) m_dc[s-6] = v[1:0];
    else if (s == 9) begin
      m_st[0] = {v[7:6], v[2:0]};
      m_st[1] = {v[15:14], v[10:8]};
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0; mret_valid = 1'b0; csr_we = 1'b0;
  endtask

  task automatic check_all(string tag);
    for (int s = 0; s < NSEL; s++) begin
      csr_sel = 4'(s);
      #1;
      checks++;
      if (csr_rdata !== exp_rd(s)) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", tag, s, csr_rdata, exp_rd(s));
      end
    end
  endtask

  task automatic do_trap(logic [31:0] pc, logic [31:0] c, logic [1:0] d, logic [4:0] st);
    trap_valid = 1'b1; trap_pc = pc; trap_cause = c; trap_dcause = d;
    cur_ptyp = st[4:3]; cur_mpp = st[2:1]; cur_mpie = st[0];
    step();
    m_push(pc, c, d, st);
  endtask

  task automatic do_mret();
    logic taken;
    taken = !m_cau[0][31];
    mret_valid = 1'b1;
    step();
    if (taken) m_pop();
  endtask

  task automatic do_write(int s, logic [31:0] v);
    csr_sel = 4'(s); csr_wdata = v; csr_we = 1'b1;
    step();
    m_write(s, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before the run ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trap_valid = 1'b0; mret_valid = 1'b0; csr_we = 1'b0;
    trap_pc = '0; trap_cause = '0; trap_dcause = '0; cur_mpp = '0; cur_mpie = 1'b0;
    cur_ptyp = '0; csr_sel = '0; csr_wdata = '0;
    for (int i = 0; i < 3; i++) begin m_epc[i] = '0; m_cau[i] = '0; m_dc[i] = '0; end
    m_st[0] = '0; m_st[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R8: every mapped register written with a distinct pattern
    for (int s = 0; s < 10; s++) do_write(s, 32'h1357_9BDF ^ (32'(s) * 32'h0101_0101));
    check_all("R8");
    // R9: all-ones into status and detail cause
    do_write(9, 32'hFFFF_FFFF);
    do_write(7, 32'hFFFF_FFFF);
    check_all("R9");
    // R11: unmapped codes
    for (int s = 10; s < NSEL; s++) do_write(s, 32'hDEAD_BEEF);
    check_all("R11");

    // R2 R3 R4 R7 R5: sweep of nested entries with interleaved pops
    do_write(3, 32'h0000_0002);
    for (int k = 0; k < 32; k++) begin
      do_trap(32'h0000_1000 + 32'(k) * 4, {1'b0, 26'(k), 5'(k)}, 2'(k), 5'(k));
      check_all("R2/R3/R4/R7");
      if (k % 3 == 2) begin
        do_mret();
        check_all("R5");
      end
    end
    // R5: drain below the occupied levels; the oldest keeps its value
    for (int k = 0; k < 4; k++) begin
      do_mret();
      check_all("R5");
    end

    // R6: return from an interrupt-type cause leaves all untouched
    do_write(3, 32'h8000_000B);
    do_mret();
    check_all("R6");
    do_mret();
    check_all("R6");

    // R10: software write racing a trap entry
    csr_sel = 4'd0; csr_wdata = 32'hAAAA_5555; csr_we = 1'b1;
    do_trap(32'h0000_2220, 32'h0000_0007, 2'd3, 5'b10101);
    check_all("R10");
    // R10: software write racing a taken pop
    csr_sel = 4'd1; csr_wdata = 32'h5555_AAAA; csr_we = 1'b1;
    do_mret();
    check_all("R10");
    // R10: trap and return in the same cycle
    mret_valid = 1'b1;
    do_trap(32'h0000_3330, 32'h0000_0005, 2'd1, 5'b01010);
    check_all("R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule